// File: doc/BRIEF.md
# Cycle-Budgeted Model Run Controller

This block lets a host step a hardware model forward by an exact number of clock cycles and then hold it still. The host loads a cycle budget over a small register bus and issues a run command. While the controller executes, it raises a synchronous clock-enable to the model and takes one from the budget for every enabled cycle. When the budget is spent, the model is frozen and the controller stops until the host loads a new budget and runs again.

A run is also pre-empted as soon as the model's outbound message buffer reports data. The controller withholds the enable at once and keeps the remaining budget. It waits until the host has emptied that buffer. After the drain it either resumes with the cycles left or, if none are left, stops. Everything runs on one clock. The model sees only an enable and never a gated clock.

Top module: `run_budget_ctrl`

## Requirements
- R1: After reset the controller is stopped, the budget reads 0 and `model_ce` is low.
- R2: A write to address 0 while stopped loads the budget from `bus_wdata`. A read of address 0 always returns the current remaining budget.
- R3: A write with `bus_wdata[0]`=1 to address 1 while stopped, with a nonzero budget N, starts execution on the next clock. `model_ce` is then high for exactly N cycles, and the budget drops by one after each enabled cycle.
- R4: When the budget reaches zero with no message pending, the controller returns to stopped one cycle later and keeps `model_ce` low until a new budget and run command arrive.
- R5: A run command issued while the budget is zero is ignored, and the controller stays stopped with `model_ce` low.
- R6: While `msg_pending` is high, `model_ce` is low in the same cycle. A pending message seen while executing moves the controller to the drain-wait state on the next clock, with the budget unchanged.
- R7: In drain-wait with a nonzero budget, the cycle after `msg_pending` falls the controller executes again. The enabled cycles before and after the pre-emption add up to the original budget.
- R8: Budget writes made while executing or in drain-wait are discarded, and the budget keeps counting or holding as if no write had occurred.
- R9: If a message is pending when the budget has just reached zero, the controller enters drain-wait with a budget of 0, and after the drain it goes to stopped rather than executing.
- R10: A read of address 2 returns the status word: bits [1:0] hold the state (0 stopped, 1 executing, 2 drain-wait), bit 2 holds `msg_pending`, and bits [8+CNT_W-1:8] hold the remaining budget. All other bits are 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Word address: 0 budget, 1 command, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| msg_pending | input | 1 | Model's outbound message buffer is not empty |
| model_ce | output | 1 | Clock enable for the model |

## Verification
A corrupted state or budget shows at the ports either as a wrong number of `model_ce` cycles for a run or as an enable that stays high while a message is pending. The bench counts enables per run over a sweep of budgets, so an off-by-one shows when that run ends. A budget that should have been held shows on the next status read, which is one cycle after the event. A wrong state code shows in the status word in the cycle after the clock edge that caused it.

// File: rtl/run_budget_pkg.sv
// Package: shared state encoding and register addresses for the run controller.
// Assumes word addressing on a narrow register bus.
package run_budget_pkg;

    typedef enum logic [1:0] {
        RS_STOP  = 2'd0,
        RS_EXEC  = 2'd1,
        RS_DRAIN = 2'd2
    } run_state_e;

    localparam int unsigned REG_BUDGET = 0;
    localparam int unsigned REG_CMD    = 1;
    localparam int unsigned REG_STATUS = 2;
    localparam int unsigned STAT_CNT_LSB = 8;

endpackage

// File: rtl/budget_counter.sv
// Module: holds the remaining cycle budget. Loads on request, counts down on request.
// Assumes the caller never asks to count down at zero.
module budget_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);

    // Budget register: reset, load, or count down by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (dec_en) begin
            count <= count - 1'b1;
        end
    end

    // Zero detect for the sequencer.
    always_comb is_zero = (count == '0);

endmodule

// File: rtl/run_seq_fsm.sv
// Module: sequencer for stop / execute / drain-wait.
// Drives the model enable and the budget decrement, and grants budget loads only while stopped.
// Assumes msg_pending is already synchronous to clk.
module run_seq_fsm
    import run_budget_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_req,
    input  logic       msg_pending,
    input  logic       cnt_zero,
    output run_state_e state,
    output logic       model_ce,
    output logic       dec_en,
    output logic       load_ok
);

    run_state_e state_nx;

    // Next-state selection; a pending message outranks an empty budget.
    always_comb begin
        state_nx = state;
        case (state)
            RS_STOP:  if (run_req && !cnt_zero) state_nx = RS_EXEC;
            RS_EXEC: begin
                if (msg_pending)   state_nx = RS_DRAIN;
                else if (cnt_zero) state_nx = RS_STOP;
            end
            RS_DRAIN: if (!msg_pending) state_nx = cnt_zero ? RS_STOP : RS_EXEC;
            default:  state_nx = RS_STOP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_STOP;
        else        state <= state_nx;
    end

    // Enable and decrement only while executing with budget and no pending message.
    always_comb begin
        model_ce = (state == RS_EXEC) && !msg_pending && !cnt_zero;
        dec_en   = model_ce;
        load_ok  = (state == RS_STOP);
    end

endmodule

// File: rtl/bus_regif.sv
// Module: register bus decode and readback for the run controller.
// Assumes single-cycle accesses; reads are combinational from the address.
module bus_regif
    import run_budget_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  run_state_e        state,
    input  logic              msg_pending,
    input  logic [CNT_W-1:0]  count,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val,
    output logic              run_req
);

    logic wr_hit;

    // Write strobes for the budget and command registers.
    always_comb begin
        wr_hit   = bus_sel && bus_wr;
        load_req = wr_hit && (bus_addr == ADDR_W'(REG_BUDGET));
        run_req  = wr_hit && (bus_addr == ADDR_W'(REG_CMD)) && bus_wdata[0];
        load_val = bus_wdata[CNT_W-1:0];
    end

    // Readback mux: budget, status word, or zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_BUDGET)) begin
            bus_rdata[CNT_W-1:0] = count;
        end else if (bus_addr == ADDR_W'(REG_STATUS)) begin
            bus_rdata[1:0] = state;
            bus_rdata[2]   = msg_pending;
            bus_rdata[STAT_CNT_LSB +: CNT_W] = count;
        end
    end

endmodule

// File: rtl/run_budget_ctrl.sv
// Top: cycle-budgeted model run controller. Connects the register interface, the sequencer and the budget counter.
// Assumes CNT_W + 8 <= DATA_W so that the budget fits into the status word.
module run_budget_ctrl
    import run_budget_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              msg_pending,
    output logic              model_ce
);

    run_state_e       state;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;
    logic             dec_en;
    logic             load_ok;
    logic             load_req;
    logic             run_req;
    logic             load_en;

    // Budget loads are honoured only while stopped.
    always_comb load_en = load_req && load_ok;

    bus_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .state       (state),
        .msg_pending (msg_pending),
        .count       (count),
        .load_req    (load_req),
        .load_val    (load_val),
        .run_req     (run_req)
    );

    run_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req     (run_req),
        .msg_pending (msg_pending),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .model_ce    (model_ce),
        .dec_en      (dec_en),
        .load_ok     (load_ok)
    );

    budget_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .dec_en   (dec_en),
        .count    (count),
        .is_zero  (cnt_zero)
    );

endmodule

// File: rtl/run_budget_ctrl_chk.sv
// Checker: temporal properties of the run controller, attached by bind.
// Assumes the state encoding from run_budget_pkg.
module run_budget_ctrl_chk
    import run_budget_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_pending,
    input logic             model_ce,
    input run_state_e       state,
    input logic [CNT_W-1:0] count
);

    a_r6_msg_blocks_ce: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pending |-> !model_ce);

    a_r3_dec_per_enable: assert property (@(posedge clk) disable iff (!rst_n)
        model_ce |=> (count == $past(count) - 1'b1));

    a_r4_zero_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_EXEC && count == '0 && !msg_pending) |=> (state == RS_STOP));

    a_r5_zero_run_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_STOP && count == '0) |=> (state == RS_STOP));

    a_r6_exec_to_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_EXEC && msg_pending) |=> (state == RS_DRAIN && $stable(count)));

    a_r8_drain_holds_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DRAIN) |=> $stable(count));

    a_r9_drain_empty_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DRAIN && count == '0 && !msg_pending) |=> (state == RS_STOP));

    a_r1_ce_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
        model_ce |-> (state == RS_EXEC));

endmodule

bind run_budget_ctrl run_budget_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_pending (msg_pending),
    .model_ce    (model_ce),
    .state       (state),
    .count       (count)
);

// File: tb/test_run_budget_ctrl.sv
// Bench: sweeps budgets, pre-emptions and corner cases, with expectations computed here.
module test_run_budget_ctrl;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              msg_pending = 1'b0;
    logic              model_ce;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    run_budget_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_run_budget_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_pending(msg_pending), .model_ce(model_ce)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        wait (cycles > 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write commits on the following rising edge.
    task automatic bus_write(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr[ADDR_W-1:0]; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input int addr, output logic [31:0] val);
        bus_addr = addr[ADDR_W-1:0];
        #1;
        val = bus_rdata;
    endtask

    function automatic logic [31:0] status_word(input int st, input logic pend, input int cnt);
        return (32'(cnt) << 8) | (32'(pend) << 2) | 32'(st);
    endfunction

    // Counts enabled cycles until the status shows stopped.
    task automatic run_count(output int ces, output int cyc);
        logic [31:0] s;
        ces = 0; cyc = 0;
        forever begin
            #1;
            if (model_ce) ces++;
            peek(2, s);
            if (s[1:0] == 2'd0) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        int ces, cyc, pre;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(2, v); check("R1 status after reset", v, status_word(0, 0, 0));
        check("R1 ce after reset", {31'd0, model_ce}, 32'd0);

        // R5: run with zero budget is ignored
        bus_write(1, 1);
        peek(2, v); check("R5 zero-budget run ignored", v, status_word(0, 0, 0));
        @(negedge clk); #1;
        check("R5 ce stays low", {31'd0, model_ce}, 32'd0);
        @(negedge clk);

        // R2/R3/R4: sweep budgets 1..12
        for (int n = 1; n <= 12; n++) begin
            bus_write(0, n);
            peek(0, v); check("R2 budget readback", v, n);
            peek(2, v); check("R10 status stopped with budget", v, status_word(0, 0, n));
            bus_write(1, 1);
            peek(2, v); check("R3 executing after run", v, status_word(1, 0, n));
            run_count(ces, cyc);
            check("R3 enable count equals budget", ces, n);
            check("R4 stop one cycle after zero", cyc, n + 1);
            @(negedge clk); #1;
            check("R4 ce low after stop", {31'd0, model_ce}, 32'd0);
            @(negedge clk);
        end

        // R6/R7/R8/R10: pre-emption after k enabled cycles, sweep k
        for (int k = 1; k <= 6; k++) begin
            bus_write(0, 10);
            bus_write(1, 1);
            repeat (k - 1) @(negedge clk);
            // k-1 rising edges since entering execute: budget is 10-(k-1)
            msg_pending = 1'b1;
            #1;
            check("R6 ce drops with pending", {31'd0, model_ce}, 32'd0);
            @(negedge clk);
            pre = 10 - (k - 1);
            peek(2, v); check("R10 drain status", v, status_word(2, 1, pre));
            bus_write(0, 99);
            peek(0, v); check("R8 write in drain discarded", v, pre);
            repeat (2) @(negedge clk);
            #1; check("R6 ce low in drain", {31'd0, model_ce}, 32'd0);
            msg_pending = 1'b0;
            @(negedge clk);
            peek(2, v); check("R7 resume executing", v, status_word(1, 0, pre));
            run_count(ces, cyc);
            check("R7 total enables equal budget", ces + (k - 1), 10);
            @(negedge clk);
        end

        // R8: write while executing is discarded
        bus_write(0, 20);
        bus_write(1, 1);
        bus_write(0, 5);
        peek(0, v); check("R8 write in execute discarded", v, 19);
        run_count(ces, cyc);
        check("R8 remaining enables", ces, 19);
        @(negedge clk);

        // R9: message appears as the budget reaches zero
        bus_write(0, 2);
        bus_write(1, 1);
        repeat (2) @(negedge clk);
        peek(2, v); check("R9 exec at zero budget", v, status_word(1, 0, 0));
        msg_pending = 1'b1;
        @(negedge clk);
        peek(2, v); check("R9 drain with zero budget", v, status_word(2, 1, 0));
        msg_pending = 1'b0;
        @(negedge clk);
        peek(2, v); check("R9 stop after drain", v, status_word(0, 0, 0));
        #1; check("R9 ce low", {31'd0, model_ce}, 32'd0);

        // R10: unused address reads zero
        peek(3, v); check("R10 address 3 reads zero", v, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule